// File: doc/BRIEF.md
# Three-Wire Serial Clock-Calendar Register Responder

This block is the device end of a three-wire serial link (chip enable, serial clock, bidirectional data split into a data input and a data output with enable). It stores seven timekeeping bytes, a control byte whose top bit is a write protect, a trickle-charge configuration byte and a small scratch RAM. A host opens a transaction by raising chip enable and shifting in a command byte, then either writes or reads one register or streams a run of registers in one burst.

The three link inputs are oversampled by the block's system clock through a synchronizer, so the serial clock must run several times slower than `clk`. The block never advances time by itself. It only stores what the link writes and returns it. Its register contents are also driven onto plain outputs for the surrounding logic.

Top module: `rtc_serial_responder`

## Requirements
- R1: A command byte is shifted in least-significant bit first, one bit per rising serial-clock edge. Bit 7 must be 1, bit 6 selects RAM (1) or clock space (0), bits 5:1 give the address, and bit 0 selects read (1) or write (0). A command with bit 7 clear is ignored: no register changes and the data output stays disabled until chip enable falls.
- R2: In clock space, address 0 holds seconds, then minutes, hours, date, month, day of week and year at addresses 1 to 6. Address 7 is the control byte and address 8 is the trickle byte (write commands 0x80 to 0x90). Clock-space addresses 9 to 30 read as 0x00 and ignore writes.
- R3: While control bit 7 is 1 at the start of a transaction, writes to every register and to RAM are dropped. A single write to the control byte itself is always accepted.
- R4: After reset, seconds is 0x80 (halt flag set), date, month and day are 0x01, control is 0x80, and every other register is 0x00.
- R5: Unused bits are stored and read as zero. The kept-bit masks are: seconds 0xFF, minutes 0x7F, hours 0xBF, date 0x3F, month 0x1F, day 0x07, year 0xFF, control 0x80, trickle 0xFF.
- R6: On a read, the first data bit (bit 0) appears after the first falling serial-clock edge that follows the last command bit. Each later bit appears after the next falling edge. `dout_oe` is high only during this read data phase and only while chip enable is high.
- R7: A clock-space read at address 31 streams eight bytes in one transaction: clock addresses 0 to 6, then the control byte.
- R8: A clock-space write at address 31 takes eight bytes, the eighth destined for control. Nothing changes until the eighth byte arrives. All eight are then applied together, and only if write protect was clear when the command was decoded.
- R9: RAM holds RAM_DEPTH bytes at RAM addresses 0 to RAM_DEPTH-1. A RAM-space access at address 31 streams RAM addresses 0 upward through RAM_DEPTH-1, and in a write each byte is stored as it completes.
- R10: Dropping chip enable at any bit discards a partial byte and returns the block to waiting for a new command byte.
- R11: `clock_halt` follows seconds bit 7, and `hour_12h` follows hours bit 7. `charge_en` is 1 exactly when the trickle byte's upper nibble is 1010.
- R12: A non-burst access covers one byte. Further serial clocks in the same transaction are ignored and leave the output disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Link chip enable, active high |
| sclk | input | 1 | Link serial clock |
| din | input | 1 | Link data from host |
| dout | output | 1 | Link data to host |
| dout_oe | output | 1 | Output enable for `dout` |
| time_regs | output | 56 | Clock bytes 0 to 6, seconds in bits 7:0 |
| ctrl_reg | output | 8 | Control byte |
| trickle_reg | output | 8 | Trickle configuration byte |
| clock_halt | output | 1 | Halt flag from seconds |
| hour_12h | output | 1 | 12-hour mode flag from hours |
| charge_en | output | 1 | Trickle enable pattern present |

## Verification
A wrong shift count or a wrong address step shows up in the first read byte as a rotated or misplaced value, within one byte time of the fault. A write-protect latch that is wrong, or a burst that commits early, appears on `time_regs` and `ctrl_reg` a few system clocks after the offending byte, before chip enable falls. A state machine that fails to return to idle after an abort or a bad command is seen when the next transaction's read returns garbage, or when `dout_oe` rises where it should stay low.

// File: rtl/rtc_resp_pkg.sv
package rtc_resp_pkg;

  typedef enum logic [2:0] {
    S_CMD,
    S_WRITE,
    S_RDARM,
    S_READ,
    S_DONE
  } eng_state_t;

  localparam int CLK_REGS      = 9;
  localparam int CTRL_IDX      = 7;
  localparam int TRICKLE_IDX   = 8;
  localparam int CLK_BURST_LEN = 8;
  localparam int ADDR_W        = 5;
  localparam logic [ADDR_W-1:0] BURST_ADDR = 5'h1F;

  // kept bits per clock-space register
  function automatic logic [7:0] field_mask(input logic [3:0] idx);
    case (idx)
      4'd0:    field_mask = 8'hFF;
      4'd1:    field_mask = 8'h7F;
      4'd2:    field_mask = 8'hBF;
      4'd3:    field_mask = 8'h3F;
      4'd4:    field_mask = 8'h1F;
      4'd5:    field_mask = 8'h07;
      4'd6:    field_mask = 8'hFF;
      4'd7:    field_mask = 8'h80;
      4'd8:    field_mask = 8'hFF;
      default: field_mask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reset_value(input int idx);
    case (idx)
      0:       reset_value = 8'h80;
      3, 4, 5: reset_value = 8'h01;
      7:       reset_value = 8'h80;
      default: reset_value = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/rtc_pin_sync.sv
module rtc_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] pins_s
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_nx;

    always_comb begin
      chain_nx = {chain_q[STAGES-2:0], pins[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_nx;
    end

    assign pins_s[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/rtc_link_engine.sv
module rtc_link_engine
  import rtc_resp_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic [7:0]        rd_data,
  output logic              cmd_start,
  output logic              wr_en,
  output logic [7:0]        wr_data,
  output logic              acc_ram,
  output logic              acc_burst,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              dout,
  output logic              dout_oe
);

  localparam int CNT_W = 4;
  localparam logic [5:0] RAM_LEN = 6'(RAM_DEPTH);
  localparam logic [5:0] CLK_LEN = 6'(CLK_BURST_LEN);

  eng_state_t        state_q, state_nx;
  logic [7:0]        sh_q, sh_nx;
  logic [CNT_W-1:0]  bcnt_q, bcnt_nx;
  logic [ADDR_W-1:0] beat_q, beat_nx;
  logic [5:0]        cmd_q, cmd_nx;   // command bits 6:1
  logic              sclk_d;
  logic              rise, fall;
  logic [5:0]        blen, beat_p1;
  logic              last_beat;

  assign rise      = sclk_s & ~sclk_d;
  assign fall      = ~sclk_s & sclk_d;
  assign acc_ram   = cmd_q[5];
  assign acc_burst = (cmd_q[4:0] == BURST_ADDR);
  assign blen      = acc_ram ? RAM_LEN : CLK_LEN;
  assign beat_p1   = {1'b0, beat_q} + 6'd1;
  assign last_beat = (beat_p1 >= blen);
  assign wr_data   = {din_s, sh_q[7:1]};

  always_comb begin
    if (!acc_burst)            acc_addr = cmd_q[4:0];
    else if (state_q == S_READ) acc_addr = beat_q + 5'd1;
    else                       acc_addr = beat_q;
  end

  always_comb begin
    state_nx  = state_q;
    sh_nx     = sh_q;
    bcnt_nx   = bcnt_q;
    beat_nx   = beat_q;
    cmd_nx    = cmd_q;
    cmd_start = 1'b0;
    wr_en     = 1'b0;
    if (!ce_s) begin
      state_nx = S_CMD;
      bcnt_nx  = '0;
      beat_nx  = '0;
    end else begin
      case (state_q)
        S_CMD: if (rise) begin
          sh_nx = {din_s, sh_q[7:1]};
          if (bcnt_q == 4'd7) begin
            cmd_nx    = sh_nx[6:1];
            cmd_start = 1'b1;
            bcnt_nx   = '0;
            beat_nx   = '0;
            if (!din_s)       state_nx = S_DONE;
            else if (sh_nx[0]) state_nx = S_RDARM;
            else              state_nx = S_WRITE;
          end else begin
            bcnt_nx = bcnt_q + 4'd1;
          end
        end
        S_WRITE: if (rise) begin
          sh_nx = {din_s, sh_q[7:1]};
          if (bcnt_q == 4'd7) begin
            wr_en   = 1'b1;
            bcnt_nx = '0;
            if (acc_burst && !last_beat) beat_nx = beat_q + 5'd1;
            else                         state_nx = S_DONE;
          end else begin
            bcnt_nx = bcnt_q + 4'd1;
          end
        end
        S_RDARM: if (fall) begin
          sh_nx    = rd_data;
          bcnt_nx  = 4'd1;
          state_nx = S_READ;
        end
        S_READ: if (fall) begin
          if (bcnt_q == 4'd8) begin
            if (acc_burst && !last_beat) begin
              beat_nx = beat_q + 5'd1;
              sh_nx   = rd_data;
              bcnt_nx = 4'd1;
            end else begin
              state_nx = S_DONE;
            end
          end else begin
            sh_nx   = {1'b0, sh_q[7:1]};
            bcnt_nx = bcnt_q + 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_CMD;
      sh_q    <= '0;
      bcnt_q  <= '0;
      beat_q  <= '0;
      cmd_q   <= '0;
      sclk_d  <= 1'b0;
    end else begin
      state_q <= state_nx;
      sh_q    <= sh_nx;
      bcnt_q  <= bcnt_nx;
      beat_q  <= beat_nx;
      cmd_q   <= cmd_nx;
      sclk_d  <= sclk_s;
    end
  end

  assign dout    = sh_q[0];
  assign dout_oe = (state_q == S_READ) && ce_s;

  // R10
  abort_to_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> (state_q == S_CMD && bcnt_q == '0));

  // R6
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_READ && !fall) |=> $stable(dout));

  // R1
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= 4'd8);

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE && ce_s) |=> (state_q == S_DONE && !dout_oe));

endmodule

// File: rtl/rtc_reg_bank.sv
module rtc_reg_bank
  import rtc_resp_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_start,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_data,
  input  logic                          acc_ram,
  input  logic                          acc_burst,
  input  logic [ADDR_W-1:0]             acc_addr,
  output logic [7:0]                    rd_data,
  output logic [CLK_REGS-1:0][7:0]      regs
);

  localparam int STAGE_N = CLK_BURST_LEN - 1;

  logic [CLK_REGS-1:0][7:0] clk_q, clk_nx;
  logic [7:0]               stage_q [STAGE_N];
  logic [7:0]               ram_q   [RAM_DEPTH];
  logic                     wp_q;
  logic                     single_we, burst_commit, stage_we, ram_we;

  assign single_we    = wr_en && !acc_ram && !acc_burst;
  assign stage_we     = wr_en && !acc_ram && acc_burst && (acc_addr < ADDR_W'(STAGE_N));
  assign burst_commit = wr_en && !acc_ram && acc_burst && (acc_addr == ADDR_W'(CTRL_IDX)) && !wp_q;
  assign ram_we       = wr_en && acc_ram && (acc_addr < ADDR_W'(RAM_DEPTH)) && !wp_q;

  always_comb begin
    clk_nx = clk_q;
    if (single_we) begin
      if (acc_addr == ADDR_W'(CTRL_IDX))
        clk_nx[CTRL_IDX] = wr_data & field_mask(4'(CTRL_IDX));
      else if (acc_addr < ADDR_W'(CLK_REGS) && !wp_q)
        clk_nx[acc_addr[3:0]] = wr_data & field_mask(acc_addr[3:0]);
    end
    if (burst_commit) begin
      for (int i = 0; i < STAGE_N; i++) clk_nx[i] = stage_q[i] & field_mask(4'(i));
      clk_nx[CTRL_IDX] = wr_data & field_mask(4'(CTRL_IDX));
    end
  end

  for (genvar r = 0; r < CLK_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      clk_q[r] <= reset_value(r);
      else if (wr_en)  clk_q[r] <= clk_nx[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wp_q <= 1'b1;
    else if (cmd_start) wp_q <= clk_q[CTRL_IDX][7];
  end

  always_ff @(posedge clk) begin
    if (stage_we) stage_q[acc_addr[2:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (ram_we) ram_q[acc_addr] <= wr_data;
  end

  always_comb begin
    rd_data = 8'h00;
    if (acc_ram) begin
      if (acc_addr < ADDR_W'(RAM_DEPTH)) rd_data = ram_q[acc_addr];
    end else if (acc_addr < ADDR_W'(CLK_REGS)) begin
      rd_data = clk_q[acc_addr[3:0]];
    end
  end

  assign regs = clk_q;

  // R3
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wp_q && !(single_we && acc_addr == ADDR_W'(CTRL_IDX))) |=> $stable(clk_q));

  // R8
  burst_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_ram && acc_burst && acc_addr != ADDR_W'(CTRL_IDX)) |=> $stable(clk_q));

  // R5
  ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q[CTRL_IDX][6:0] == 7'd0);

  // R5
  day_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_q[5][7:3] == 5'd0);

endmodule

// File: rtl/rtc_serial_responder.sv
module rtc_serial_responder
  import rtc_resp_pkg::*;
#(
  parameter int RAM_DEPTH   = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce,
  input  logic        sclk,
  input  logic        din,
  output logic        dout,
  output logic        dout_oe,
  output logic [55:0] time_regs,
  output logic [7:0]  ctrl_reg,
  output logic [7:0]  trickle_reg,
  output logic        clock_halt,
  output logic        hour_12h,
  output logic        charge_en
);

  logic [2:0]               pins_s;
  logic                     cmd_start, wr_en, acc_ram, acc_burst;
  logic [7:0]               wr_data, rd_data;
  logic [ADDR_W-1:0]        acc_addr;
  logic [CLK_REGS-1:0][7:0] regs;

  rtc_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   ({din, sclk, ce}),
    .pins_s (pins_s)
  );

  rtc_link_engine #(.RAM_DEPTH(RAM_DEPTH)) i_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s      (pins_s[0]),
    .sclk_s    (pins_s[1]),
    .din_s     (pins_s[2]),
    .rd_data   (rd_data),
    .cmd_start (cmd_start),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .acc_ram   (acc_ram),
    .acc_burst (acc_burst),
    .acc_addr  (acc_addr),
    .dout      (dout),
    .dout_oe   (dout_oe)
  );

  rtc_reg_bank #(.RAM_DEPTH(RAM_DEPTH)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .acc_ram   (acc_ram),
    .acc_burst (acc_burst),
    .acc_addr  (acc_addr),
    .rd_data   (rd_data),
    .regs      (regs)
  );

  assign time_regs   = regs[6:0];
  assign ctrl_reg    = regs[CTRL_IDX];
  assign trickle_reg = regs[TRICKLE_IDX];
  assign clock_halt  = regs[0][7];
  assign hour_12h    = regs[2][7];
  assign charge_en   = (regs[TRICKLE_IDX][7:4] == 4'b1010);

endmodule

// File: tb/test_rtc_serial_responder.sv
module test_rtc_serial_responder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int DEPTH      = 31;

  logic        clk = 1'b0;
  logic        rst_n, ce, sclk, din;
  logic        dout, dout_oe, clock_halt, hour_12h, charge_en;
  logic [55:0] time_regs;
  logic [7:0]  ctrl_reg, trickle_reg;

  rtc_serial_responder #(.RAM_DEPTH(DEPTH)) i_rtc_serial_responder (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .time_regs(time_regs),
    .ctrl_reg(ctrl_reg), .trickle_reg(trickle_reg),
    .clock_halt(clock_halt), .hour_12h(hour_12h), .charge_en(charge_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;
  logic [7:0] m_clk [9];
  logic [7:0] m_ram [DEPTH];

  function automatic logic [7:0] kmask(input int i);
    logic [7:0] m;
    m = 8'h00;
    if (i == 0 || i == 6 || i == 8) m = 8'hFF;
    if (i == 1) m = 8'h7F;
    if (i == 2) m = 8'hBF;
    if (i == 3) m = 8'h3F;
    if (i == 4) m = 8'h1F;
    if (i == 5) m = 8'h07;
    if (i == 7) m = 8'h80;
    return m;
  endfunction

  function automatic logic [55:0] model_time();
    logic [55:0] t;
    for (int i = 0; i < 7; i++) t[i*8 +: 8] = m_clk[i];
    return t;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_open();
    @(negedge clk); sclk = 1'b0; din = 1'b0; ce = 1'b1;
    idle(HALF);
  endtask

  task automatic xfer_close();
    @(negedge clk); sclk = 1'b0;
    idle(HALF);
    @(negedge clk); ce = 1'b0;
    idle(2*HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sclk = 1'b0; din = b[i];
      idle(HALF);
      @(negedge clk); sclk = 1'b1;
      idle(HALF);
    end
  endtask

  task automatic recv(output logic [7:0] b, output bit all_oe, output bit any_oe);
    all_oe = 1'b1; any_oe = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sclk = 1'b0;
      idle(HALF);
      b[i] = dout; all_oe &= dout_oe; any_oe |= dout_oe;
      @(negedge clk); sclk = 1'b1;
      idle(HALF);
    end
  endtask

  function automatic logic [7:0] mkcmd(input bit ram, input int addr, input bit rd);
    return {1'b1, ram, 5'(addr), rd};
  endfunction

  task automatic wr_reg(input bit ram, input int addr, input logic [7:0] d);
    bit wp;
    wp = m_clk[7][7];
    xfer_open(); send_bits(mkcmd(ram, addr, 1'b0), 8); send_bits(d, 8); xfer_close();
    if (!ram) begin
      if (addr == 7) m_clk[7] = d & 8'h80;
      else if (addr <= 8 && !wp) m_clk[addr] = d & kmask(addr);
    end else if (addr < DEPTH && !wp) begin
      m_ram[addr] = d;
    end
  endtask

  task automatic rd_reg(input bit ram, input int addr, output logic [7:0] b, output bit oe_ok);
    bit any;
    xfer_open(); send_bits(mkcmd(ram, addr, 1'b1), 8); recv(b, oe_ok, any); xfer_close();
  endtask

  task automatic clk_burst_wr(input logic [7:0] d [8], input int nbytes);
    bit wp;
    wp = m_clk[7][7];
    xfer_open(); send_bits(8'hBE, 8);
    for (int i = 0; i < nbytes; i++) send_bits(d[i], 8);
    xfer_close();
    if (nbytes == 8 && !wp) begin
      for (int i = 0; i < 7; i++) m_clk[i] = d[i] & kmask(i);
      m_clk[7] = d[7] & 8'h80;
    end
  endtask

  initial begin
    logic [7:0] b;
    logic [7:0] bw [8];
    bit ok, any;
    rst_n = 1'b0; ce = 1'b0; sclk = 1'b0; din = 1'b0;
    for (int i = 0; i < 9; i++) m_clk[i] = 8'h00;
    m_clk[0] = 8'h80; m_clk[3] = 8'h01; m_clk[4] = 8'h01; m_clk[5] = 8'h01; m_clk[7] = 8'h80;
    idle(5);
    @(negedge clk); rst_n = 1'b1;
    idle(5);

    // R4 reset state, R11 flags
    check("R4 time", time_regs, model_time());
    check("R4 ctrl", ctrl_reg, 8'h80);
    check("R4 trickle", trickle_reg, 8'h00);
    check("R11 halt after reset", clock_halt, 1'b1);
    check("R6 oe idle", dout_oe, 1'b0);

    // R3 protected write dropped
    wr_reg(1'b0, 0, 8'h12);
    check("R3 protected sec", time_regs, model_time());
    rd_reg(1'b0, 0, b, ok);
    check("R6 read sec", b, 8'h80);
    check("R6 oe during read", ok, 1'b1);
    check("R6 oe after close", dout_oe, 1'b0);

    // R3 control always writable, R5 control mask
    wr_reg(1'b0, 7, 8'hFF);
    check("R5 ctrl mask", ctrl_reg, 8'h80);
    wr_reg(1'b0, 7, 8'h00);
    check("R3 ctrl unprotect", ctrl_reg, 8'h00);

    // R2 R5 sweep of clock space
    for (int a = 0; a < 13; a++) begin
      if (a == 7) continue;
      wr_reg(1'b0, a, 8'hFF);
      rd_reg(1'b0, a, b, ok);
      check($sformatf("R5 mask addr %0d", a), b, (a <= 8) ? kmask(a) : 8'h00);
      wr_reg(1'b0, a, 8'((a * 8'h11) ^ 8'h5A));
      rd_reg(1'b0, a, b, ok);
      check($sformatf("R2 value addr %0d", a), b, (a <= 8) ? m_clk[a] : 8'h00);
    end
    check("R2 time port", time_regs, model_time());
    check("R2 trickle port", trickle_reg, m_clk[8]);

    // R11 hour mode, halt flag, charge enable
    wr_reg(1'b0, 2, 8'h92);
    check("R11 12h set", hour_12h, 1'b1);
    wr_reg(1'b0, 2, 8'h23);
    check("R11 24h", hour_12h, 1'b0);
    wr_reg(1'b0, 0, 8'h45);
    check("R11 halt clear", clock_halt, 1'b0);
    for (int n = 0; n < 16; n++) begin
      wr_reg(1'b0, 8, {4'(n), 4'h5});
      check($sformatf("R11 charge nibble %0d", n), charge_en, (n == 10));
    end

    // R9 RAM single sweep
    for (int a = 0; a < DEPTH; a++) wr_reg(1'b1, a, 8'(a * 37 + 11));
    for (int a = 0; a < DEPTH; a++) begin
      rd_reg(1'b1, a, b, ok);
      check($sformatf("R9 ram %0d", a), b, m_ram[a]);
    end

    // R7 clock burst read
    xfer_open(); send_bits(8'hBF, 8);
    for (int i = 0; i < 8; i++) begin
      recv(b, ok, any);
      check($sformatf("R7 burst byte %0d", i), b, m_clk[i]);
      check("R6 burst oe", ok, 1'b1);
    end
    xfer_close();

    // R8 partial burst has no effect
    for (int i = 0; i < 8; i++) bw[i] = 8'(8'h31 + i * 3);
    bw[7] = 8'h00;
    clk_burst_wr(bw, 7);
    check("R8 partial burst", time_regs, model_time());
    clk_burst_wr(bw, 8);
    check("R8 full burst", time_regs, model_time());
    check("R8 full burst ctrl", ctrl_reg, 8'h00);
    bw[7] = 8'h80;
    clk_burst_wr(bw, 8);
    check("R8 burst sets wp", ctrl_reg, 8'h80);
    for (int i = 0; i < 7; i++) bw[i] = 8'h09;
    bw[7] = 8'h00;
    clk_burst_wr(bw, 8);
    check("R8 protected burst time", time_regs, model_time());
    check("R8 protected burst ctrl", ctrl_reg, 8'h80);

    // R3 RAM protected
    wr_reg(1'b1, 0, 8'hEE);
    wr_reg(1'b0, 7, 8'h00);
    rd_reg(1'b1, 0, b, ok);
    check("R3 protected ram", b, m_ram[0]);

    // R9 RAM burst write then read
    xfer_open(); send_bits(8'hFE, 8);
    for (int a = 0; a < DEPTH; a++) begin
      send_bits(8'(8'hC3 ^ (a * 5)), 8);
      m_ram[a] = 8'(8'hC3 ^ (a * 5));
    end
    xfer_close();
    xfer_open(); send_bits(8'hFF, 8);
    for (int a = 0; a < DEPTH; a++) begin
      recv(b, ok, any);
      check($sformatf("R9 ram burst %0d", a), b, m_ram[a]);
    end
    xfer_close();

    // R10 abort mid data and mid command
    xfer_open(); send_bits(mkcmd(1'b0, 1, 1'b0), 8); send_bits(8'h00, 5); xfer_close();
    check("R10 abort data", time_regs, model_time());
    xfer_open(); send_bits(mkcmd(1'b0, 1, 1'b1), 3); xfer_close();
    rd_reg(1'b0, 1, b, ok);
    check("R10 command after abort", b, m_clk[1]);

    // R1 invalid command ignored
    xfer_open(); send_bits(8'h03, 8); recv(b, ok, any); xfer_close();
    check("R1 invalid read oe", any, 1'b0);
    xfer_open(); send_bits(8'h02, 8); send_bits(8'h77, 8); xfer_close();
    check("R1 invalid write", time_regs, model_time());
    check("R1 invalid write ctrl", ctrl_reg, 8'h00);

    // R12 single access ends after one byte
    xfer_open(); send_bits(mkcmd(1'b0, 3, 1'b1), 8); recv(b, ok, any);
    check("R12 first byte", b, m_clk[3]);
    recv(b, ok, any);
    check("R12 extra byte oe", any, 1'b0);
    xfer_close();
    xfer_open(); send_bits(mkcmd(1'b0, 4, 1'b0), 8); send_bits(8'h07, 8); send_bits(8'h09, 8); xfer_close();
    m_clk[4] = 8'h07;
    check("R12 extra write byte", time_regs, model_time());

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule